// File: doc/BRIEF.md
# Stereo Digital Source Mixer

The block builds four 16-bit signed sample streams: a left and a right stream for the playback path, and a left and a right stream for the capture path. Each stream is the saturated sum of any subset of its four candidate sources. The candidates are drawn from eight input samples: two time slots of the first audio interface, the second audio interface, and the converter path, each with a left and a right channel. Two plain 16-bit control words choose the sources, one for the playback mixer and one for the capture mixer. In the capture mixer each side can also take the opposite channel of the second interface.

All eight input samples share one valid/ready handshake. A sample set is accepted on a clock edge where `in_valid` and `in_ready` are both high. The enable words are sampled on that same edge. The four mixed results appear in the output register on that edge, with `out_valid` high, and stay there until the consumer raises `out_ready`. Back-pressure works as a single-entry pipeline: `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `src_mixer`

## Requirements
- R1: In `play_en`, bits 15, 14, 13 and 12 add in slot-0 left, slot-1 left, second-interface left and converter left to `play_l`.
- R2: In `play_en`, bits 11, 10, 9 and 8 add in slot-0 right, slot-1 right, second-interface right and converter right to `play_r`.
- R3: In `cap_en`, bits 15, 14, 13 and 12 add in slot-0 left, second-interface left, converter left and second-interface right (crossed) to `cap_l`.
- R4: In `cap_en`, bits 11, 10, 9 and 8 add in slot-0 right, second-interface right, converter right and second-interface left (crossed) to `cap_r`.
- R5: Sums are formed without overflow and then clamped to the range -32768 to 32767. Intermediate values that leave this range do not wrap.
- R6: An output whose four enable bits are all zero is 0.
- R7: The outputs and `out_valid` are registered from the inputs and enable words present at the accepting edge. `out_valid` drops one clock after the result is taken with no new sample accepted.
- R8: Bits 7:0 of both enable words have no effect on any output.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs do not change. Any `in_valid` in that window is not accepted.
- R10: After reset, `out_valid` is low and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample set valid |
| in_ready | output | 1 | Mixer can accept a sample set |
| s0_l | input | 16 | First interface, slot 0, left |
| s0_r | input | 16 | First interface, slot 0, right |
| s1_l | input | 16 | First interface, slot 1, left |
| s1_r | input | 16 | First interface, slot 1, right |
| if2_l | input | 16 | Second interface, left |
| if2_r | input | 16 | Second interface, right |
| cv_l | input | 16 | Converter path, left |
| cv_r | input | 16 | Converter path, right |
| play_en | input | 16 | Playback source enables (bits 15:8 used) |
| cap_en | input | 16 | Capture source enables (bits 15:8 used) |
| out_valid | output | 1 | Mixed results valid |
| out_ready | input | 1 | Consumer takes the results |
| play_l | output | 16 | Playback left mix |
| play_r | output | 16 | Playback right mix |
| cap_l | output | 16 | Capture left mix |
| cap_r | output | 16 | Capture right mix |

## Verification
Each input carries a distinct magnitude, so every sum names exactly the set of sources that went into it. Single-bit and single-side enables tell a correct bit map apart from a swapped one. They also tell it apart from a map that adds a channel into the wrong side, and the crossed capture bits are tried on their own. Large same-sign inputs in both polarities separate clamping from wrap-around. A positive full-scale sample added to a negative full-scale one checks that cancellation is exact. Enables that sit only in bits 7:0, a stalled consumer and a new input offered during the stall show that ignored bits and refused samples leave the outputs unchanged.

// File: rtl/mix_pkg.sv
package mix_pkg;
  // Ordinal of each candidate within a mixer lane; enable bit = top - ordinal.
  localparam int unsigned LANES = 4;
  typedef enum logic [1:0] {
    LANE_PLAY_L = 2'd0,
    LANE_PLAY_R = 2'd1,
    LANE_CAP_L  = 2'd2,
    LANE_CAP_R  = 2'd3
  } lane_e;
endpackage

// File: rtl/mix_sum.sv
module mix_sum #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        y
);
  localparam int unsigned AW = W + $clog2(N) + 1;
  localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [AW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (en[i]) acc = acc + $signed({{(AW-W){src[i][W-1]}}, src[i]});
    end
  end

  always_comb begin
    if (acc > MAXV)      y = MAXV[W-1:0];
    else if (acc < MINV) y = MINV[W-1:0];
    else                 y = acc[W-1:0];
  end

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (y == '0));
  assert_clamp_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (y == MAXV[W-1:0]) |-> (acc >= MAXV));
  assert_clamp_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (y == MINV[W-1:0]) |-> (acc <= MINV));
endmodule

// File: rtl/mix_ostage.sv
module mix_ostage #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] d,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] q
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else begin
      if (take) q <= d;
      if (take)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/src_mixer.sv
module src_mixer #(
  parameter int unsigned W     = 16,
  parameter int unsigned NSRC  = 4,
  parameter int unsigned CFG_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] s0_l,
  input  logic [W-1:0] s0_r,
  input  logic [W-1:0] s1_l,
  input  logic [W-1:0] s1_r,
  input  logic [W-1:0] if2_l,
  input  logic [W-1:0] if2_r,
  input  logic [W-1:0] cv_l,
  input  logic [W-1:0] cv_r,
  input  logic [CFG_W-1:0] play_en,
  input  logic [CFG_W-1:0] cap_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] play_l,
  output logic [W-1:0] play_r,
  output logic [W-1:0] cap_l,
  output logic [W-1:0] cap_r
);
  import mix_pkg::*;
  localparam int unsigned LEFT_TOP  = CFG_W - 1;
  localparam int unsigned RIGHT_TOP = CFG_W - 1 - NSRC;
  localparam int unsigned DW        = LANES * W;

  logic [LANES-1:0][NSRC-1:0][W-1:0] lane_src;
  logic [LANES-1:0][NSRC-1:0]        lane_en;
  logic [LANES-1:0][W-1:0]           lane_y;
  logic [LANES-1:0][W-1:0]           lane_q;

  // Candidate ordering per lane; ordinal k uses enable bit (side top - k).
  assign lane_src[LANE_PLAY_L] = {cv_l, if2_l, s1_l, s0_l};
  assign lane_src[LANE_PLAY_R] = {cv_r, if2_r, s1_r, s0_r};
  assign lane_src[LANE_CAP_L]  = {if2_r, cv_l, if2_l, s0_l};
  assign lane_src[LANE_CAP_R]  = {if2_l, cv_r, if2_r, s0_r};

  for (genvar k = 0; k < NSRC; k++) begin : g_en
    assign lane_en[LANE_PLAY_L][k] = play_en[LEFT_TOP - k];
    assign lane_en[LANE_PLAY_R][k] = play_en[RIGHT_TOP - k];
    assign lane_en[LANE_CAP_L][k]  = cap_en[LEFT_TOP - k];
    assign lane_en[LANE_CAP_R][k]  = cap_en[RIGHT_TOP - k];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    mix_sum #(.W(W), .N(NSRC)) u_sum (
      .clk(clk), .rst_n(rst_n),
      .en(lane_en[l]), .src(lane_src[l]), .y(lane_y[l])
    );
  end

  mix_ostage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .d(lane_y), .out_valid(out_valid), .out_ready(out_ready),
    .q(lane_q)
  );

  assign play_l = lane_q[LANE_PLAY_L];
  assign play_r = lane_q[LANE_PLAY_R];
  assign cap_l  = lane_q[LANE_CAP_L];
  assign cap_r  = lane_q[LANE_CAP_R];

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && play_l == '0 && cap_r == '0));
  assert_crossed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cap_en[LEFT_TOP -: NSRC] == 4'b0001)
      |=> (cap_l == $past(if2_r)));
  assert_crossed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cap_en[RIGHT_TOP -: NSRC] == 4'b0001)
      |=> (cap_r == $past(if2_l)));
endmodule

// File: tb/src_mixer_tb_top.sv
module src_mixer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [7:0][15:0] s = '0;
  logic [15:0] play_en = '0, cap_en = '0;
  logic [15:0] play_l, play_r, cap_l, cap_r;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  src_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .s0_l(s[0]), .s0_r(s[1]), .s1_l(s[2]), .s1_r(s[3]),
    .if2_l(s[4]), .if2_r(s[5]), .cv_l(s[6]), .cv_r(s[7]),
    .play_en(play_en), .cap_en(cap_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .play_l(play_l), .play_r(play_r), .cap_l(cap_l), .cap_r(cap_r)
  );

  typedef struct packed {
    logic [7:0][15:0] src;   // index 0..7: s0_l s0_r s1_l s1_r if2_l if2_r cv_l cv_r
    logic [15:0]      pe;
    logic [15:0]      ce;
    logic [3:0][15:0] ex;    // index 0..3: play_l play_r cap_l cap_r
  } vec_t;

  localparam logic [7:0][15:0] SA = {16'd20, 16'd10, 16'd2000, 16'd1000,
                                     16'd400, 16'd300, 16'd200, 16'd100};
  localparam logic [7:0][15:0] SP = {8{16'h7530}};
  localparam logic [7:0][15:0] SN = {8{16'h8AD0}};
  localparam logic [7:0][15:0] SC = {16'd0, 16'd0, 16'h8000, 16'd0,
                                     16'd0, 16'd0, 16'd0, 16'h7FFF};

  localparam vec_t VECS [9] = '{
    '{SA, 16'hF000, 16'h0000, {16'h0000, 16'h0000, 16'h0000, 16'h0582}}, // R1 R6
    '{SA, 16'h0F00, 16'h0000, {16'h0000, 16'h0000, 16'h0A3C, 16'h0000}}, // R2
    '{SA, 16'h8000, 16'h1000, {16'h0000, 16'h07D0, 16'h0000, 16'h0064}}, // R3 crossed
    '{SA, 16'h4400, 16'h0100, {16'h03E8, 16'h0000, 16'h0190, 16'h012C}}, // R4 crossed
    '{SA, 16'h2100, 16'hEE00, {16'h08AC, 16'h0456, 16'h0014, 16'h03E8}}, // R3 R4
    '{SA, 16'h00FF, 16'h00FF, {16'h0000, 16'h0000, 16'h0000, 16'h0000}}, // R8
    '{SP, 16'hFF00, 16'hF000, {16'h0000, 16'h7FFF, 16'h7FFF, 16'h7FFF}}, // R5 high
    '{SN, 16'h9000, 16'h0300, {16'h8000, 16'h0000, 16'h0000, 16'h8000}}, // R5 low
    '{SC, 16'h0000, 16'h9000, {16'h0000, 16'hFFFF, 16'h0000, 16'h0000}}  // R5 cancel
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [3:0][15:0] ex);
    check({tag, " play_l"}, play_l, ex[0]);
    check({tag, " play_r"}, play_r, ex[1]);
    check({tag, " cap_l"},  cap_l,  ex[2]);
    check({tag, " cap_r"},  cap_r,  ex[3]);
  endtask

  initial begin : watchdog
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {15'd0, out_valid}, 16'd0);
    check_all("R10", '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: one accepted set per vector, sampled after the capturing edge
    for (int i = 0; i < 9; i++) begin
      s = VECS[i].src; play_en = VECS[i].pe; cap_en = VECS[i].ce;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R7 valid v%0d", i), {15'd0, out_valid}, 16'd1);
      check_all($sformatf("R1-4/5/6/8 v%0d", i), VECS[i].ex);
    end

    // R7 valid falls after the result is taken with no new input
    @(negedge clk);
    check("R7 drop", {15'd0, out_valid}, 16'd0);

    // R9 back-pressure: hold result, refuse new input
    out_ready = 1'b0;
    s = VECS[0].src; play_en = VECS[0].pe; cap_en = VECS[0].ce;
    in_valid = 1'b1;
    @(negedge clk);
    check("R9 in_ready low", {15'd0, in_ready}, 16'd0);
    s = VECS[1].src; play_en = VECS[1].pe; cap_en = VECS[1].ce;
    repeat (2) @(negedge clk);
    check("R9 held valid", {15'd0, out_valid}, 16'd1);
    check_all("R9 held", VECS[0].ex);
    // release: the waiting set is accepted on the draining edge
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_all("R9 after release", VECS[1].ex);

    // R8 ignored bits on top of an active selection
    s = SA; play_en = 16'h80FF; cap_en = 16'h08AA;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 play_l", play_l, 16'h0064);
    check("R8 cap_r", cap_r, 16'h00C8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule